// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policies

This block is a direct-mapped data cache placed between a processor load/store port and a slower backing memory whose read and write transfers are a whole line wide. Each line stores a tag naming the memory block it copies, a valid bit and, in write-back builds, a dirty bit. A request hits when the indexed line is valid and its stored tag equals the tag field of the request address.

Two build-time parameters pick the policy. `WRITE_BACK` chooses between write-through, where a store hit also sends the single stored word to memory, and write-back, where a store hit only marks the line dirty and memory receives the line when it is evicted. `ALLOC_ON_WRITE` chooses between allocate-on-write, where a store miss fills the line and then acts as a store hit, and write-around, where a store miss writes the word to memory and leaves the cache unchanged. Read misses always fill the whole line.

The processor side uses a valid/ready handshake with one response pulse per accepted request. An invalidate input drops all lines, and one-cycle hit and miss pulses let the environment measure the hit ratio. Addresses are word addresses split, from most to least significant, into tag, line index and word offset.

Top module: `wpol_dcache`

## Requirements
- R1: Each accepted request produces exactly one of hit_pulse_o or miss_pulse_o, once; it is a hit when the indexed line is valid and its tag matches.
- R2: A read miss fetches the whole line (mem_write_o=0, mem_addr_o with offset bits zero) so that a following read anywhere in that line hits.
- R3: In write-through builds a store hit updates the line and issues one word write: mem_write_o=1, mem_wmask_o one-hot at the word offset, the word present in every lane of mem_wdata_o.
- R4: In write-back builds a store hit causes no memory transfer and marks the line dirty; memory receives the data only through a line write (mem_wmask_o all ones) when the line is evicted.
- R5: A dirty line about to be replaced is written back first, and the fill read starts only after that write completes, never overlapping it.
- R6: With allocate-on-write a store miss fills the line, then performs the store-hit action, so a later read of the line hits.
- R7: With write-around a store miss performs only a one-word memory write and leaves the cache unchanged, so a later read of that address misses.
- R8: req_ready_o is low from the cycle after acceptance until the request completes; exactly one resp_valid_o pulse follows each accepted request, and read responses return the current value of the addressed word.
- R9: Reset or inval_i clears all valid and dirty bits: following accesses miss and discarded dirty lines are not written back.
- R10: A memory request keeps mem_valid_o, mem_write_o and mem_addr_o steady until mem_ready_i is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| inval_i | input | 1 | Clear all valid and dirty bits |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | DATA_W | Load data, valid with resp_valid_o |
| hit_pulse_o | output | 1 | Request found its line |
| miss_pulse_o | output | 1 | Request did not find its line |
| mem_valid_o | output | 1 | Memory transfer request |
| mem_ready_i | input | 1 | Memory completes the transfer this cycle |
| mem_write_o | output | 1 | 1 = write, 0 = line read |
| mem_addr_o | output | ADDR_W | Word address of the transfer |
| mem_wmask_o | output | WORDS_PER_LINE | Word enables for writes |
| mem_wdata_o | output | WORDS_PER_LINE*DATA_W | Write data, one lane per word |
| mem_rdata_i | input | WORDS_PER_LINE*DATA_W | Line read data, valid with mem_ready_i |

## Verification
The functions that meet in one request are eviction of a dirty line and the fill that replaces it, together with the store that then lands in the freshly filled line. The bench provokes this with a store to a different tag at the index of a line dirtied earlier, run on a write-back, allocate-on-write instance and on a write-through, write-around instance side by side. It judges the outcome from the backing-memory model: the evicted words must appear in memory, the line-read, line-write and word-write counts must match the counts worked out per policy, and later loads must return the stored values with the hit or miss outcome expected for each policy.

// File: rtl/wpol_pkg.sv
package wpol_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_EVICT,
      ST_FILL,
      ST_WORD
   } wpol_state_e;

   function automatic bit wpol_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/wpol_tag_store.sv
module wpol_tag_store #(
   parameter int unsigned LINES      = 8,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned TAG_W      = 5,
   parameter bit          WRITE_BACK = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inval_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             install_i,
   input  logic             mark_dirty_i,
   output logic             hit_o,
   output logic             line_valid_o,
   output logic             line_dirty_o,
   output logic [TAG_W-1:0] line_tag_o
);

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
      end else if (inval_i) begin
         valid_q <= '0;
      end else if (install_i) begin
         valid_q[idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (install_i) begin
         tag_q[idx_i] <= tag_i;
      end
   end

   assign line_valid_o = valid_q[idx_i];
   assign line_tag_o   = tag_q[idx_i];
   assign hit_o        = line_valid_o && (line_tag_o == tag_i);

   generate
      if (WRITE_BACK) begin : g_dirty
         logic [LINES-1:0] dirty_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               dirty_q <= '0;
            end else if (inval_i) begin
               dirty_q <= '0;
            end else if (install_i) begin
               dirty_q[idx_i] <= 1'b0;
            end else if (mark_dirty_i) begin
               dirty_q[idx_i] <= 1'b1;
            end
         end
         assign line_dirty_o = dirty_q[idx_i];

         assert_dirty_needs_valid_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dirty_q & ~valid_q) == '0);
      end else begin : g_clean
         logic unused_mark;
         assign unused_mark  = mark_dirty_i;
         assign line_dirty_o = 1'b0;
      end
   endgenerate

   assert_inval_clears_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      inval_i |=> (valid_q == '0));

endmodule

// File: rtl/wpol_data_store.sv
module wpol_data_store #(
   parameter int unsigned LINES          = 8,
   parameter int unsigned WORDS_PER_LINE = 4,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned IDX_W          = 3,
   parameter int unsigned OFF_W          = 2,
   localparam int unsigned LINE_W        = WORDS_PER_LINE * DATA_W
) (
   input  logic              clk_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              fill_i,
   input  logic [LINE_W-1:0] fill_line_i,
   input  logic              wr_i,
   input  logic [OFF_W-1:0]  wr_off_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [LINE_W-1:0] line_o
);

   genvar w;
   generate
      for (w = 0; w < WORDS_PER_LINE; w++) begin : g_lane
         logic [DATA_W-1:0] lane_q [LINES];
         always_ff @(posedge clk_i) begin
            if (fill_i) begin
               lane_q[idx_i] <= fill_line_i[w*DATA_W +: DATA_W];
            end else if (wr_i && (wr_off_i == OFF_W'(w))) begin
               lane_q[idx_i] <= wr_data_i;
            end
         end
         assign line_o[w*DATA_W +: DATA_W] = lane_q[idx_i];
      end
   endgenerate

endmodule

// File: rtl/wpol_dcache.sv
module wpol_dcache
   import wpol_pkg::*;
#(
   parameter int unsigned ADDR_W         = 10,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned WORDS_PER_LINE = 4,
   parameter int unsigned LINES          = 8,
   parameter bit          WRITE_BACK     = 1'b1,
   parameter bit          ALLOC_ON_WRITE = 1'b1,
   localparam int unsigned OFF_W  = $clog2(WORDS_PER_LINE),
   localparam int unsigned IDX_W  = $clog2(LINES),
   localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
   localparam int unsigned LINE_W = WORDS_PER_LINE * DATA_W
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      inval_i,
   input  logic                      req_valid_i,
   output logic                      req_ready_o,
   input  logic                      req_write_i,
   input  logic [ADDR_W-1:0]         req_addr_i,
   input  logic [DATA_W-1:0]         req_wdata_i,
   output logic                      resp_valid_o,
   output logic [DATA_W-1:0]         resp_rdata_o,
   output logic                      hit_pulse_o,
   output logic                      miss_pulse_o,
   output logic                      mem_valid_o,
   input  logic                      mem_ready_i,
   output logic                      mem_write_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic [WORDS_PER_LINE-1:0] mem_wmask_o,
   output logic [LINE_W-1:0]         mem_wdata_o,
   input  logic [LINE_W-1:0]         mem_rdata_i
);

   generate
      if (!wpol_is_pow2(WORDS_PER_LINE) || WORDS_PER_LINE < 2) begin : g_bad_words
         $error("WORDS_PER_LINE must be a power of two of at least 2");
      end
      if (!wpol_is_pow2(LINES) || LINES < 2) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
         $error("ADDR_W leaves no tag bits");
      end
   endgenerate

   wpol_state_e       state_q, state_d;
   logic              retry_q, retry_d;
   logic              rq_write_q;
   logic [ADDR_W-1:0] rq_addr_q;
   logic [DATA_W-1:0] rq_wdata_q;
   logic              resp_valid_q, resp_valid_d;
   logic [DATA_W-1:0] resp_rdata_q, resp_rdata_d;

   logic [IDX_W-1:0]  rq_idx;
   logic [TAG_W-1:0]  rq_tag;
   logic [OFF_W-1:0]  rq_off;
   logic              hit, line_valid, line_dirty;
   logic [TAG_W-1:0]  line_tag;
   logic [LINE_W-1:0] line_data;
   logic              do_install, do_mark, do_store;
   logic              accept;

   assign rq_off = rq_addr_q[OFF_W-1:0];
   assign rq_idx = rq_addr_q[OFF_W +: IDX_W];
   assign rq_tag = rq_addr_q[ADDR_W-1 -: TAG_W];
   assign accept = req_valid_i && req_ready_o;

   wpol_tag_store #(
      .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
   ) tags_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .inval_i     (inval_i),
      .idx_i       (rq_idx),
      .tag_i       (rq_tag),
      .install_i   (do_install),
      .mark_dirty_i(do_mark),
      .hit_o       (hit),
      .line_valid_o(line_valid),
      .line_dirty_o(line_dirty),
      .line_tag_o  (line_tag)
   );

   wpol_data_store #(
      .LINES(LINES), .WORDS_PER_LINE(WORDS_PER_LINE), .DATA_W(DATA_W),
      .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) data_i (
      .clk_i      (clk_i),
      .idx_i      (rq_idx),
      .fill_i     (do_install),
      .fill_line_i(mem_rdata_i),
      .wr_i       (do_store),
      .wr_off_i   (rq_off),
      .wr_data_i  (rq_wdata_q),
      .line_o     (line_data)
   );

   // Next-state and line update decisions.
   always_comb begin
      state_d      = state_q;
      retry_d      = retry_q;
      resp_valid_d = 1'b0;
      resp_rdata_d = resp_rdata_q;
      do_install   = 1'b0;
      do_mark      = 1'b0;
      do_store     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_d = ST_LOOKUP;
               retry_d = 1'b0;
            end
         end
         ST_LOOKUP: begin
            if (hit) begin
               if (!rq_write_q) begin
                  resp_valid_d = 1'b1;
                  resp_rdata_d = line_data[rq_off*DATA_W +: DATA_W];
                  state_d      = ST_IDLE;
               end else begin
                  do_store = 1'b1;
                  if (WRITE_BACK) begin
                     do_mark      = 1'b1;
                     resp_valid_d = 1'b1;
                     resp_rdata_d = rq_wdata_q;
                     state_d      = ST_IDLE;
                  end else begin
                     state_d = ST_WORD;
                  end
               end
            end else if (rq_write_q && !ALLOC_ON_WRITE) begin
               state_d = ST_WORD;
            end else if (line_valid && line_dirty) begin
               state_d = ST_EVICT;
            end else begin
               state_d = ST_FILL;
            end
         end
         ST_EVICT: begin
            if (mem_ready_i) state_d = ST_FILL;
         end
         ST_FILL: begin
            if (mem_ready_i) begin
               do_install = !inval_i;
               retry_d    = 1'b1;
               state_d    = ST_LOOKUP;
            end
         end
         ST_WORD: begin
            if (mem_ready_i) begin
               resp_valid_d = 1'b1;
               resp_rdata_d = rq_wdata_q;
               state_d      = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         retry_q      <= 1'b0;
         resp_valid_q <= 1'b0;
         resp_rdata_q <= '0;
         rq_write_q   <= 1'b0;
         rq_addr_q    <= '0;
         rq_wdata_q   <= '0;
      end else begin
         state_q      <= state_d;
         retry_q      <= retry_d;
         resp_valid_q <= resp_valid_d;
         resp_rdata_q <= resp_rdata_d;
         if (accept) begin
            rq_write_q <= req_write_i;
            rq_addr_q  <= req_addr_i;
            rq_wdata_q <= req_wdata_i;
         end
      end
   end

   // Memory port.
   always_comb begin
      mem_valid_o = 1'b0;
      mem_write_o = 1'b0;
      mem_addr_o  = {rq_tag, rq_idx, {OFF_W{1'b0}}};
      mem_wmask_o = '0;
      mem_wdata_o = {WORDS_PER_LINE{rq_wdata_q}};
      unique case (state_q)
         ST_EVICT: begin
            mem_valid_o = 1'b1;
            mem_write_o = 1'b1;
            mem_addr_o  = {line_tag, rq_idx, {OFF_W{1'b0}}};
            mem_wmask_o = '1;
            mem_wdata_o = line_data;
         end
         ST_FILL: begin
            mem_valid_o = 1'b1;
         end
         ST_WORD: begin
            mem_valid_o = 1'b1;
            mem_write_o = 1'b1;
            mem_addr_o  = rq_addr_q;
            mem_wmask_o = WORDS_PER_LINE'(1) << rq_off;
         end
         default: ;
      endcase
   end

   assign req_ready_o  = (state_q == ST_IDLE);
   assign resp_valid_o = resp_valid_q;
   assign resp_rdata_o = resp_rdata_q;
   assign hit_pulse_o  = (state_q == ST_LOOKUP) && !retry_q && hit;
   assign miss_pulse_o = (state_q == ST_LOOKUP) && !retry_q && !hit;

   // Assertions kept next to the control they watch.
   assert_one_event_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hit_pulse_o && miss_pulse_o));

   assert_busy_after_accept_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> !req_ready_o);

   assert_single_resp_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_valid_o |=> !resp_valid_o);

   assert_mem_hold_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && !mem_ready_i) |=>
         (mem_valid_o && $stable(mem_write_o) && $stable(mem_addr_o)));

   assert_evict_then_fill_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && mem_ready_i && mem_write_o && (&mem_wmask_o)) |=>
         (mem_valid_o && !mem_write_o));

   assert_fill_line_aligned_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && !mem_write_o) |-> (mem_addr_o[OFF_W-1:0] == '0));

   generate
      if (WRITE_BACK) begin : g_wb_chk
         assert_wb_hit_quiet_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == ST_LOOKUP && hit && rq_write_q) |=> !mem_valid_o);
      end else begin : g_wt_chk
         assert_wt_word_write_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == ST_LOOKUP && hit && rq_write_q) |=>
               (mem_valid_o && mem_write_o && $countones(mem_wmask_o) == 1));
         assert_wt_no_evict_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(mem_valid_o && mem_write_o && (&mem_wmask_o)));
      end
      if (ALLOC_ON_WRITE) begin : g_alloc_chk
         assert_alloc_fetches_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == ST_LOOKUP && !hit && rq_write_q) |=>
               (mem_valid_o && (!mem_write_o || (&mem_wmask_o))));
      end else begin : g_around_chk
         assert_around_word_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == ST_LOOKUP && !hit && rq_write_q) |=>
               (mem_valid_o && mem_write_o && $countones(mem_wmask_o) == 1));
      end
   endgenerate

endmodule

// File: tb/wpol_dcache_tb.sv
module wpol_dcache_tb_top;

   localparam int unsigned ADDR_W = 10;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned WORDS  = 4;
   localparam int unsigned LINES  = 8;
   localparam int unsigned LINE_W = WORDS * DATA_W;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned N_DUT  = 2;  // 0: write-back/allocate, 1: write-through/around

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;  // 50 MHz

   logic              inval     [N_DUT];
   logic              req_valid [N_DUT];
   logic              req_ready [N_DUT];
   logic              req_write [N_DUT];
   logic [ADDR_W-1:0] req_addr  [N_DUT];
   logic [DATA_W-1:0] req_wdata [N_DUT];
   logic              resp_valid[N_DUT];
   logic [DATA_W-1:0] resp_rdata[N_DUT];
   logic              hit_p     [N_DUT];
   logic              miss_p    [N_DUT];
   logic              mem_valid [N_DUT];
   logic              mem_ready [N_DUT];
   logic              mem_write [N_DUT];
   logic [ADDR_W-1:0] mem_addr  [N_DUT];
   logic [WORDS-1:0]  mem_wmask [N_DUT];
   logic [LINE_W-1:0] mem_wdata [N_DUT];
   logic [LINE_W-1:0] mem_rdata [N_DUT];

   wpol_dcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_LINE(WORDS), .LINES(LINES),
                 .WRITE_BACK(1'b1), .ALLOC_ON_WRITE(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .inval_i(inval[0]),
      .req_valid_i(req_valid[0]), .req_ready_o(req_ready[0]), .req_write_i(req_write[0]),
      .req_addr_i(req_addr[0]), .req_wdata_i(req_wdata[0]),
      .resp_valid_o(resp_valid[0]), .resp_rdata_o(resp_rdata[0]),
      .hit_pulse_o(hit_p[0]), .miss_pulse_o(miss_p[0]),
      .mem_valid_o(mem_valid[0]), .mem_ready_i(mem_ready[0]), .mem_write_o(mem_write[0]),
      .mem_addr_o(mem_addr[0]), .mem_wmask_o(mem_wmask[0]), .mem_wdata_o(mem_wdata[0]),
      .mem_rdata_i(mem_rdata[0]));

   wpol_dcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_LINE(WORDS), .LINES(LINES),
                 .WRITE_BACK(1'b0), .ALLOC_ON_WRITE(1'b0)) dut_wt_i (
      .clk_i(clk), .rst_ni(rst_n), .inval_i(inval[1]),
      .req_valid_i(req_valid[1]), .req_ready_o(req_ready[1]), .req_write_i(req_write[1]),
      .req_addr_i(req_addr[1]), .req_wdata_i(req_wdata[1]),
      .resp_valid_o(resp_valid[1]), .resp_rdata_o(resp_rdata[1]),
      .hit_pulse_o(hit_p[1]), .miss_pulse_o(miss_p[1]),
      .mem_valid_o(mem_valid[1]), .mem_ready_i(mem_ready[1]), .mem_write_o(mem_write[1]),
      .mem_addr_o(mem_addr[1]), .mem_wmask_o(mem_wmask[1]), .mem_wdata_o(mem_wdata[1]),
      .mem_rdata_i(mem_rdata[1]));

   function automatic logic [DATA_W-1:0] pat(input int unsigned a);
      return 32'h5A00_0000 + a * 32'd7 + 32'd3;
   endfunction

   // Backing memory models with a fixed latency of three cycles per transfer.
   logic [DATA_W-1:0] bmem [N_DUT][DEPTH];
   logic [1:0]        lat   [N_DUT];
   int                n_fill[N_DUT];
   int                n_lwr [N_DUT];
   int                n_wwr [N_DUT];
   int                n_hit [N_DUT];
   int                n_miss[N_DUT];
   int                n_resp[N_DUT];

   always_comb begin
      for (int d = 0; d < N_DUT; d++) begin
         mem_ready[d] = mem_valid[d] && (lat[d] == 2'd2);
         for (int w = 0; w < WORDS; w++) begin
            mem_rdata[d][w*DATA_W +: DATA_W] = bmem[d][{mem_addr[d][ADDR_W-1:2], 2'(w)}];
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int d = 0; d < N_DUT; d++) begin
         if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) bmem[d][a] <= pat(a);
            lat[d] <= '0;
            n_fill[d] <= 0; n_lwr[d] <= 0; n_wwr[d] <= 0;
            n_hit[d] <= 0; n_miss[d] <= 0; n_resp[d] <= 0;
         end else begin
            if (hit_p[d])      n_hit[d]  <= n_hit[d] + 1;
            if (miss_p[d])     n_miss[d] <= n_miss[d] + 1;
            if (resp_valid[d]) n_resp[d] <= n_resp[d] + 1;
            if (mem_valid[d]) begin
               if (lat[d] == 2'd2) begin
                  lat[d] <= '0;
                  if (mem_write[d]) begin
                     for (int w = 0; w < WORDS; w++) begin
                        if (mem_wmask[d][w])
                           bmem[d][{mem_addr[d][ADDR_W-1:2], 2'(w)}] <= mem_wdata[d][w*DATA_W +: DATA_W];
                     end
                     if (&mem_wmask[d]) n_lwr[d] <= n_lwr[d] + 1;
                     else               n_wwr[d] <= n_wwr[d] + 1;
                  end else begin
                     n_fill[d] <= n_fill[d] + 1;
                  end
               end else begin
                  lat[d] <= lat[d] + 2'd1;
               end
            end else begin
               lat[d] <= '0;
            end
         end
      end
   end

   int n_checks = 0;
   int n_fails  = 0;
   logic [DATA_W-1:0] shadow [DEPTH];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_req(input int d, input logic we, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd,
                         output logic was_hit);
      int h0, r0, guard;
      @(negedge clk);
      while (!req_ready[d]) @(negedge clk);
      h0 = n_hit[d];
      r0 = n_resp[d];
      req_valid[d] = 1'b1;
      req_write[d] = we;
      req_addr[d]  = a;
      req_wdata[d] = wd;
      @(negedge clk);
      req_valid[d] = 1'b0;
      chk(!req_ready[d], "R8", "ready low after accept", 32'(req_ready[d]), 32'd0);
      guard = 0;
      while (!resp_valid[d] && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      rd = resp_rdata[d];
      @(negedge clk);
      @(negedge clk);
      chk(n_resp[d] - r0 == 1, "R8", "one response per request", 32'(n_resp[d] - r0), 32'd1);
      was_hit = (n_hit[d] != h0);
   endtask

   typedef struct packed {
      logic              we;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] wd;
      logic              hit_wb;
      logic              hit_wt;
   } vec_t;

   localparam int N_VEC = 12;
   localparam vec_t VECS [N_VEC] = '{
      '{1'b0, 10'h004, 32'h0,          1'b0, 1'b0},
      '{1'b0, 10'h005, 32'h0,          1'b1, 1'b1},
      '{1'b1, 10'h006, 32'hAAAA_0006, 1'b1, 1'b1},
      '{1'b0, 10'h006, 32'h0,          1'b1, 1'b1},
      '{1'b1, 10'h024, 32'hBBBB_0024, 1'b0, 1'b0},
      '{1'b0, 10'h024, 32'h0,          1'b1, 1'b0},
      '{1'b0, 10'h006, 32'h0,          1'b0, 1'b0},
      '{1'b1, 10'h048, 32'hCCCC_0048, 1'b0, 1'b0},
      '{1'b0, 10'h048, 32'h0,          1'b1, 1'b0},
      '{1'b0, 10'h049, 32'h0,          1'b1, 1'b1},
      '{1'b1, 10'h3FF, 32'hDDDD_03FF, 1'b0, 1'b0},
      '{1'b0, 10'h3FF, 32'h0,          1'b1, 1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fails);
      $finish;
   end

   initial begin
      logic [DATA_W-1:0] rd;
      logic hit;
      for (int d = 0; d < N_DUT; d++) begin
         inval[d] = 1'b0; req_valid[d] = 1'b0; req_write[d] = 1'b0;
         req_addr[d] = '0; req_wdata[d] = '0;
      end
      for (int a = 0; a < DEPTH; a++) shadow[a] = pat(a);
      repeat (3) @(negedge clk);
      // Reset state (R8, R9)
      for (int d = 0; d < N_DUT; d++) begin
         chk(req_ready[d] && !resp_valid[d] && !mem_valid[d] && !hit_p[d] && !miss_p[d],
             "R9", "reset outputs", {req_ready[d], resp_valid[d], mem_valid[d]}, 32'h4);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: hit/miss outcome per policy (R1, R2, R6, R7) and data (R8).
      for (int v = 0; v < N_VEC; v++) begin
         for (int d = 0; d < N_DUT; d++) begin
            do_req(d, VECS[v].we, VECS[v].addr, VECS[v].wd, rd, hit);
            chk(hit == ((d == 0) ? VECS[v].hit_wb : VECS[v].hit_wt), "R1",
                $sformatf("vector %0d dut %0d hit", v, d), 32'(hit),
                32'((d == 0) ? VECS[v].hit_wb : VECS[v].hit_wt));
            if (!VECS[v].we)
               chk(rd == shadow[VECS[v].addr], "R8", $sformatf("vector %0d dut %0d load", v, d),
                   rd, shadow[VECS[v].addr]);
         end
         if (VECS[v].we) shadow[VECS[v].addr] = VECS[v].wd;
      end

      // Transfer counts worked out per policy.
      chk(n_fill[0] == 5, "R2", "wb line reads", 32'(n_fill[0]), 32'd5);
      chk(n_lwr[0] == 2,  "R5", "wb dirty evictions", 32'(n_lwr[0]), 32'd2);
      chk(n_wwr[0] == 0,  "R4", "wb word writes", 32'(n_wwr[0]), 32'd0);
      chk(n_fill[1] == 5, "R2", "wt line reads", 32'(n_fill[1]), 32'd5);
      chk(n_lwr[1] == 0,  "R3", "wt line writes", 32'(n_lwr[1]), 32'd0);
      chk(n_wwr[1] == 4,  "R7", "wt word writes", 32'(n_wwr[1]), 32'd4);
      chk(bmem[0][10'h024] == 32'hBBBB_0024, "R5", "evicted word reached memory",
          bmem[0][10'h024], 32'hBBBB_0024);
      chk(bmem[0][10'h006] == 32'hAAAA_0006, "R4", "dirty word written on eviction",
          bmem[0][10'h006], 32'hAAAA_0006);

      // Invalidate: next access misses and dirty lines are dropped (R9).
      @(negedge clk);
      inval[0] = 1'b1; inval[1] = 1'b1;
      @(negedge clk);
      inval[0] = 1'b0; inval[1] = 1'b0;
      for (int d = 0; d < N_DUT; d++) begin
         do_req(d, 1'b0, 10'h005, '0, rd, hit);
         chk(!hit, "R9", $sformatf("dut %0d miss after invalidate", d), 32'(hit), 32'd0);
         chk(rd == shadow[10'h005], "R9", "load after invalidate", rd, shadow[10'h005]);
      end
      chk(n_lwr[0] == 2, "R9", "no write-back of discarded lines", 32'(n_lwr[0]), 32'd2);

      // Store miss: allocate keeps memory stale, write-around updates memory.
      for (int d = 0; d < N_DUT; d++) do_req(d, 1'b1, 10'h3FE, 32'hEEEE_03FE, rd, hit);
      shadow[10'h3FE] = 32'hEEEE_03FE;
      chk(bmem[0][10'h3FE] == pat(10'h3FE), "R4", "lazy write keeps memory stale",
          bmem[0][10'h3FE], pat(10'h3FE));
      chk(bmem[1][10'h3FE] == 32'hEEEE_03FE, "R7", "write-around reaches memory",
          bmem[1][10'h3FE], 32'hEEEE_03FE);
      do_req(0, 1'b0, 10'h3FE, '0, rd, hit);
      chk(hit, "R6", "allocated line hits", 32'(hit), 32'd1);
      chk(rd == 32'hEEEE_03FE, "R6", "allocated line holds store", rd, 32'hEEEE_03FE);
      do_req(1, 1'b0, 10'h3FE, '0, rd, hit);
      chk(!hit, "R7", "write-around left cache unchanged", 32'(hit), 32'd0);
      chk(rd == 32'hEEEE_03FE, "R7", "load after write-around", rd, 32'hEEEE_03FE);

      // Write-through store hit sends the word at once (R3).
      do_req(1, 1'b1, 10'h3FD, 32'hF00D_03FD, rd, hit);
      chk(hit, "R3", "store hit", 32'(hit), 32'd1);
      chk(bmem[1][10'h3FD] == 32'hF00D_03FD, "R3", "word written through",
          bmem[1][10'h3FD], 32'hF00D_03FD);
      chk(n_wwr[1] == 6, "R3", "word write count", 32'(n_wwr[1]), 32'd6);
      do_req(1, 1'b0, 10'h3FD, '0, rd, hit);
      chk(hit && rd == 32'hF00D_03FD, "R3", "cache updated on store hit", rd, 32'hF00D_03FD);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule